// File: doc/BRIEF.md
# Programmable Second-Order Recursive Filter Section

This block is a single biquad: a second-order recursive filter stage in direct form, built around 8-bit signed samples and 8-bit signed coefficients. Each accepted input sample is combined with the two previous inputs and the two previous feedback values. Five 8x8 multipliers form the terms. Three feedforward products are summed first. The two feedback products are then taken away through a cascade of two subtractors. All sums are carried in 16 bits.

The upper byte of the 16-bit sum becomes the new feedback value in the delay line. The full 16-bit sum passes through a two-stage arithmetic right shifter, controlled by a 3-bit scale input, on its way to the registered output.

The coefficients are written at run time through a small write port: a write enable, an address and a data byte. A synchronous reset clears every coefficient, the delay line and the output.

The section accepts one sample per clock. It delivers the matching result one clock later.

Top module: `iir2_section`

## Requirements
- R1: While reset is high at a clock edge, the output valid, the output data, all five coefficients and the four delay registers become zero, so a sample taken just after reset yields 0.
- R2: `res_valid_o` is high in exactly the cycle after a cycle with `smp_valid_i` high, and low after every cycle with `smp_valid_i` low.
- R3: A write with `cf_we_i` high stores `cf_wdata_i` into the coefficient at `cf_addr_i`: 0 is the gain on the current input, 1 on the previous input, 2 on the input before that, 3 on the previous feedback value and 4 on the feedback value before that. Writes to addresses 5, 6 and 7 change nothing.
- R4: The 16-bit sum is c0·x + c1·x1 + c2·x2 − c3·y1 − c4·y2 modulo 2^16 in two's complement. Each product is the signed 8x8 product of one coefficient and one operand.
- R5: On each accepted sample, x1 takes the input and x2 takes the old x1. y1 takes bits [15:8] of the new sum, read as a signed byte, and y2 takes the old y1.
- R6: Cycles with `smp_valid_i` low leave the delay registers unchanged. Results after an idle gap therefore match those of the same samples sent back to back.
- R7: `res_data_o` is the 16-bit sum arithmetically shifted right by a + b bits. a is 0, 1, 2 or 4 for `scale_i[1:0]` equal to 0, 1, 2 or 3. b is 3 when `scale_i[2]` is 1 and 0 otherwise. The scale is taken in the same cycle as the sample.
- R8: `res_data_o` keeps its last value through cycles with no accepted sample.
- R9: A coefficient written in the same cycle as a sample is accepted does not affect that sample's result. It applies from the next sample on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| smp_valid_i | input | 1 | Input sample strobe |
| smp_data_i | input | 8 | Signed input sample |
| scale_i | input | 3 | Output shift selection |
| cf_we_i | input | 1 | Coefficient write enable |
| cf_addr_i | input | 3 | Coefficient select |
| cf_wdata_i | input | 8 | Signed coefficient value |
| res_valid_o | output | 1 | Result valid, one clock after the sample |
| res_data_o | output | 16 | Scaled signed result |

## Verification
Every result, along with its valid flag, is due at the first rising edge after the sample is accepted. A coefficient write takes effect at that same edge, so it shapes only later samples.

The bench drives each cycle's inputs on the falling edge. It advances its integer model at the rising edge, in the same order the hardware uses: first the sample with the old coefficients, then the write. It compares both outputs on the next falling edge.

Idle cycles are compared as well. This confirms that the valid flag drops and that the data and the delay state hold.

// File: rtl/iir2_pkg.sv
`timescale 1ns/1ps
package iir2_pkg;
    // number of gains in one second-order section
    localparam int NUM_COEF = 5;

    // gain slot order decoded by the write port
    typedef enum logic [2:0] {
        SLOT_FF0 = 3'd0,
        SLOT_FF1 = 3'd1,
        SLOT_FF2 = 3'd2,
        SLOT_FB1 = 3'd3,
        SLOT_FB2 = 3'd4
    } coef_slot_e;
endpackage

// File: rtl/iir2_coef_bank.sv
`timescale 1ns/1ps
module iir2_coef_bank
    import iir2_pkg::*;
#(
    parameter int COEF_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic                             clk_i,
    input  logic                             rst_i,
    input  logic                             we_i,
    input  logic [ADDR_W-1:0]                addr_i,
    input  logic [COEF_W-1:0]                wdata_i,
    output logic [NUM_COEF-1:0][COEF_W-1:0]  coef_o
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_COEF - 1);

    logic [NUM_COEF-1:0][COEF_W-1:0] bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we_i && (addr_i <= LAST_ADDR)) begin
            bank_d[addr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign coef_o = bank_q;

    // R3: a write to an unused slot leaves every gain as it was
    assert_ignore_addr_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (we_i && (addr_i > LAST_ADDR)) |=> $stable(coef_o));

    // R3: a write to a used slot lands in that slot
    assert_write_slot_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (we_i && (addr_i <= LAST_ADDR)) |=> (coef_o[$past(addr_i)] == $past(wdata_i)));
endmodule

// File: rtl/iir2_mac.sv
`timescale 1ns/1ps
module iir2_mac
    import iir2_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    parameter int ACC_W  = 16
) (
    input  logic signed [DATA_W-1:0]         x0_i,
    input  logic signed [DATA_W-1:0]         x1_i,
    input  logic signed [DATA_W-1:0]         x2_i,
    input  logic signed [DATA_W-1:0]         y1_i,
    input  logic signed [DATA_W-1:0]         y2_i,
    input  logic [NUM_COEF-1:0][COEF_W-1:0]  coef_i,
    output logic signed [ACC_W-1:0]          sum_o,
    output logic signed [DATA_W-1:0]         fb_o
);
    localparam int PROD_W = DATA_W + COEF_W;

    logic signed [DATA_W-1:0] opnd  [NUM_COEF];
    logic signed [ACC_W-1:0]  term  [NUM_COEF];
    logic signed [ACC_W-1:0]  ff_sum;
    logic signed [ACC_W-1:0]  fb_stage1;

    always_comb begin
        opnd[SLOT_FF0] = x0_i;
        opnd[SLOT_FF1] = x1_i;
        opnd[SLOT_FF2] = x2_i;
        opnd[SLOT_FB1] = y1_i;
        opnd[SLOT_FB2] = y2_i;
    end

    for (genvar i = 0; i < NUM_COEF; i++) begin : g_mul
        logic signed [PROD_W-1:0] prod;
        assign prod = opnd[i] * $signed(coef_i[i]);
        if (ACC_W >= PROD_W) begin : g_ext
            assign term[i] = ACC_W'(prod);
        end else begin : g_cut
            assign term[i] = prod[ACC_W-1:0];
        end
    end

    // feedforward adder tree, then the two feedback subtractors in cascade
    always_comb begin
        ff_sum    = term[SLOT_FF0] + term[SLOT_FF1] + term[SLOT_FF2];
        fb_stage1 = ff_sum - term[SLOT_FB1];
        sum_o     = fb_stage1 - term[SLOT_FB2];
        fb_o      = sum_o[ACC_W-1 -: DATA_W];
    end
endmodule

// File: rtl/iir2_scaler.sv
`timescale 1ns/1ps
module iir2_scaler #(
    parameter int ACC_W = 16
) (
    input  logic signed [ACC_W-1:0] val_i,
    input  logic [2:0]              scale_i,
    output logic signed [ACC_W-1:0] val_o
);
    logic signed [ACC_W-1:0] stage1;
    logic [2:0]              coarse_sh;

    // first stage: 0, 1, 2 or 4 places
    always_comb begin
        case (scale_i[1:0])
            2'd0:    coarse_sh = 3'd0;
            2'd1:    coarse_sh = 3'd1;
            2'd2:    coarse_sh = 3'd2;
            default: coarse_sh = 3'd4;
        endcase
        stage1 = val_i >>> coarse_sh;
    end

    // second stage: 0 or 3 places
    always_comb begin
        val_o = scale_i[2] ? (stage1 >>> 3) : stage1;
    end

    // R7: an arithmetic shift keeps the sign of the sum
    always_comb begin
        assert_sign_kept_R7: assert (val_o[ACC_W-1] == val_i[ACC_W-1])
            else $error("scaler changed the sign");
    end
endmodule

// File: rtl/iir2_section.sv
`timescale 1ns/1ps
module iir2_section
    import iir2_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int COEF_W  = 8,
    parameter int ACC_W   = 16,
    parameter int ADDR_W  = 3
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              smp_valid_i,
    input  logic [DATA_W-1:0] smp_data_i,
    input  logic [2:0]        scale_i,
    input  logic              cf_we_i,
    input  logic [ADDR_W-1:0] cf_addr_i,
    input  logic [COEF_W-1:0] cf_wdata_i,
    output logic              res_valid_o,
    output logic [ACC_W-1:0]  res_data_o
);
    typedef struct packed {
        logic signed [DATA_W-1:0] x1;
        logic signed [DATA_W-1:0] x2;
        logic signed [DATA_W-1:0] y1;
        logic signed [DATA_W-1:0] y2;
        logic                     vld;
        logic signed [ACC_W-1:0]  dat;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_COEF-1:0][COEF_W-1:0] coef;
    logic signed [ACC_W-1:0]         sum;
    logic signed [DATA_W-1:0]        fb;
    logic signed [ACC_W-1:0]         scaled;

    iir2_coef_bank #(.COEF_W(COEF_W), .ADDR_W(ADDR_W)) u_bank (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .we_i    (cf_we_i),
        .addr_i  (cf_addr_i),
        .wdata_i (cf_wdata_i),
        .coef_o  (coef)
    );

    iir2_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
        .x0_i   ($signed(smp_data_i)),
        .x1_i   (st_q.x1),
        .x2_i   (st_q.x2),
        .y1_i   (st_q.y1),
        .y2_i   (st_q.y2),
        .coef_i (coef),
        .sum_o  (sum),
        .fb_o   (fb)
    );

    iir2_scaler #(.ACC_W(ACC_W)) u_scale (
        .val_i   (sum),
        .scale_i (scale_i),
        .val_o   (scaled)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = smp_valid_i;
        if (smp_valid_i) begin
            st_d.x1  = $signed(smp_data_i);
            st_d.x2  = st_q.x1;
            st_d.y1  = fb;
            st_d.y2  = st_q.y1;
            st_d.dat = scaled;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid_o = st_q.vld;
    assign res_data_o  = st_q.dat;

    // R1: reset empties the output
    assert_reset_clear_R1: assert property (@(posedge clk_i)
        rst_i |=> (!res_valid_o && (res_data_o == '0)));

    // R2: valid follows the input strobe by one clock
    assert_valid_rise_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        smp_valid_i |=> res_valid_o);
    assert_valid_fall_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !smp_valid_i |=> !res_valid_o);

    // R5: delay line moves one place per sample
    assert_delay_chain_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        smp_valid_i |=> ((st_q.x2 == $past(st_q.x1)) && (st_q.y2 == $past(st_q.y1))));

    // R5: with no shift, the stored feedback is the top byte of the result
    assert_fb_upper_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (smp_valid_i && (scale_i == 3'd0)) |=> (st_q.y1 == $signed(res_data_o[ACC_W-1 -: DATA_W])));

    // R6: idle cycles freeze the delay line
    assert_idle_freeze_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        !smp_valid_i |=> ($stable(st_q.x1) && $stable(st_q.x2) && $stable(st_q.y1) && $stable(st_q.y2)));

    // R8: output data holds between samples
    assert_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !smp_valid_i |=> $stable(res_data_o));
endmodule

// File: tb/sim_iir2_section.sv
`timescale 1ns/1ps
module sim_iir2_section;
    logic        clk = 1'b0;
    logic        rst;
    logic        smp_valid;
    logic [7:0]  smp_data;
    logic [2:0]  scale;
    logic        cf_we;
    logic [2:0]  cf_addr;
    logic [7:0]  cf_wdata;
    logic        res_valid;
    logic [15:0] res_data;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    // reference model state
    int cf[5];
    int mx1, mx2, my1, my2;
    int exp_data;
    bit exp_valid;

    always #5 clk = ~clk;

    iir2_section u0 (
        .clk_i       (clk),
        .rst_i       (rst),
        .smp_valid_i (smp_valid),
        .smp_data_i  (smp_data),
        .scale_i     (scale),
        .cf_we_i     (cf_we),
        .cf_addr_i   (cf_addr),
        .cf_wdata_i  (cf_wdata),
        .res_valid_o (res_valid),
        .res_data_o  (res_data)
    );

    function automatic int shift_of(input int sc);
        int a;
        case (sc & 3)
            0: a = 0;
            1: a = 1;
            2: a = 2;
            default: a = 4;
        endcase
        return a + (((sc >> 2) & 1) != 0 ? 3 : 0);
    endfunction

    function automatic int wrap16(input int v);
        int w;
        w = v & 16'hFFFF;
        if (w >= 32768) w = w - 65536;
        return w;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 5; i++) cf[i] = 0;
        mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
        exp_data = 0; exp_valid = 1'b0;
    endtask

    task automatic compare(input string tag);
        int got;
        got = int'($signed(res_data));
        vectors++;
        if (res_valid !== exp_valid || got != exp_data) begin
            fails++;
            $display("FAIL %s: valid=%0b data=%0d expected valid=%0b data=%0d",
                     tag, res_valid, got, exp_valid, exp_data);
        end
    endtask

    // one clock: drive, let the edge pass, advance the model, compare
    task automatic cycle(input bit v, input int d, input int sc,
                         input bit we, input int ad, input int wd, input string tag);
        int acc;
        smp_valid = v;
        smp_data  = d[7:0];
        scale     = sc[2:0];
        cf_we     = we;
        cf_addr   = ad[2:0];
        cf_wdata  = wd[7:0];
        @(posedge clk);
        if (v) begin
            acc = wrap16(cf[0]*d + cf[1]*mx1 + cf[2]*mx2 - cf[3]*my1 - cf[4]*my2);
            exp_data  = acc >>> shift_of(sc);
            exp_valid = 1'b1;
            mx2 = mx1; mx1 = d;
            my2 = my1; my1 = acc >>> 8;
        end else begin
            exp_valid = 1'b0;
        end
        if (we && ad < 5) cf[ad] = wd;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic load(input int ad, input int wd, input string tag);
        cycle(1'b0, 0, 0, 1'b1, ad, wd, tag);
    endtask

    initial begin
        rst = 1'b1;
        smp_valid = 1'b0; smp_data = '0; scale = '0;
        cf_we = 1'b1; cf_addr = 3'd0; cf_wdata = 8'h55;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0; cf_we = 1'b0;
        // R1: output cleared after reset
        compare("R1 reset state");
        // R1: coefficients cleared, so a sample yields zero
        cycle(1'b1, 55, 0, 1'b0, 0, 0, "R1 zero gains");
        cycle(1'b1, -90, 0, 1'b0, 0, 0, "R1 zero gains");

        // R3: load the five gains, output must hold (R8) meanwhile
        load(0, 32, "R3 R8 load");
        load(1, 64, "R3 R8 load");
        load(2, 32, "R3 R8 load");
        load(3, -40, "R3 R8 load");
        load(4, 20, "R3 R8 load");

        // R4 R5: impulse response
        cycle(1'b1, 100, 0, 1'b0, 0, 0, "R4 impulse");
        for (int i = 0; i < 10; i++) cycle(1'b1, 0, 0, 1'b0, 0, 0, "R5 impulse tail");

        // R6 R2: samples with idle gaps between them
        for (int i = 0; i < 6; i++) begin
            cycle(1'b1, 20 * i - 60, 0, 1'b0, 0, 0, "R6 gapped sample");
            cycle(1'b0, 127, 0, 1'b0, 0, 0, "R2 R6 idle");
            cycle(1'b0, -128, 5, 1'b0, 0, 0, "R8 idle hold");
        end

        // R7: all eight scale settings on a step input
        for (int s = 0; s < 8; s++) cycle(1'b1, 50, s, 1'b0, 0, 0, "R7 scale sweep");
        for (int s = 0; s < 8; s++) cycle(1'b1, -77, s, 1'b0, 0, 0, "R7 negative scale");

        // R3: writes to unused slots must change nothing
        load(5, 99, "R3 unused slot");
        load(6, -99, "R3 unused slot");
        load(7, 127, "R3 unused slot");
        for (int i = 0; i < 4; i++) cycle(1'b1, 40 - 30 * i, 0, 1'b0, 0, 0, "R3 after unused writes");

        // R9: gain written together with a sample
        cycle(1'b1, 70, 0, 1'b1, 0, -100, "R9 same-cycle write");
        cycle(1'b1, 70, 0, 1'b0, 0, 0, "R9 next sample");
        cycle(1'b1, 10, 1, 1'b1, 3, 90, "R9 same-cycle feedback write");
        cycle(1'b1, 10, 1, 1'b0, 0, 0, "R9 next sample");

        // R4: mixed traffic with large gains (wraparound)
        for (int i = 0; i < 300; i++) begin
            cycle(($urandom % 4) != 0, int'($urandom % 256) - 128, int'($urandom % 8),
                  ($urandom % 5) == 0, int'($urandom % 8), int'($urandom % 256) - 128,
                  "R4 mixed traffic");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule